// File: doc/BRIEF.md
# Rounding and Packing Unit

This block is the last step of a double-precision arithmetic datapath. It receives a result that has already been normalized: a sign, a signed biased exponent wide enough to go below zero or past the top of the range, the 52 fraction bits kept after truncation, and the guard, round and sticky bits. It rounds the fraction under one of four modes, then checks the exponent range. It then produces the 64-bit IEEE-754 double with overflow, underflow and invalid status.

The rounding mode and the suppression of the invalid status come from an 8-bit control byte presented alongside each operand. An upstream stage raises an invalid indication, and the block forwards it unless the control byte silences it. There is no subnormal output. An exponent at or below zero produces a signed zero and an underflow flag. An exponent at or above the all-ones code produces a signed infinity and an overflow flag. Results leave one clock after they enter, tagged by a valid strobe.

Top module: `round_pack`

## Requirements
- R1: An operand presented with `in_valid` high appears at the outputs on the next clock with `out_valid` high. `out_valid` is low in the cycle after a cycle without `in_valid`, and the result and flags then keep their previous values. Reset clears every output to zero.
- R2: With `ctrl[7:6]` = 00 (nearest, ties away from zero), the fraction is incremented exactly when the guard bit is 1.
- R3: With `ctrl[7:6]` = 01 (nearest, ties to even), the fraction is incremented exactly when guard is 1 and at least one of round, sticky or fraction bit 0 is 1.
- R4: With `ctrl[7:6]` = 10 (toward +infinity), a positive result is incremented when any of guard, round or sticky is 1. A negative result is never incremented.
- R5: With `ctrl[7:6]` = 11 (truncate), the fraction is never incremented.
- R6: When the increment carries out of an all-ones fraction, the fraction becomes zero and the exponent goes up by one.
- R7: If the exponent after rounding is 2047 or more (and R8 does not apply), `out_ovf` is 1 and the result is the signed infinity: the sign, exponent field all ones, fraction zero. Any other in-range result has an exponent field between 1 and 2046.
- R8: If the incoming exponent is 0 or negative, `out_unf` is 1, `out_ovf` is 0 and the result is zero except for the sign at bit 63.
- R9: `out_inv` equals `in_invalid` when `ctrl[5]` is 1 and is 0 when `ctrl[5]` is 0. `ctrl[4:0]` has no effect on any output.
- R10: A normal result has the sign at bit 63, the rounded exponent at bits 62:52 and the rounded fraction at bits 51:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | 13 | Signed biased exponent after normalization |
| in_frac | input | 52 | Truncated fraction |
| in_guard | input | 1 | First bit below the fraction |
| in_round | input | 1 | Second bit below the fraction |
| in_sticky | input | 1 | OR of all lower bits |
| in_invalid | input | 1 | Invalid indication from upstream |
| ctrl | input | 8 | [7:6] rounding mode, [5] silent (active low), [4:0] ignored |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Packed double |
| out_ovf | output | 1 | Overflow status |
| out_unf | output | 1 | Underflow status |
| out_inv | output | 1 | Invalid status after masking |

## Verification
The bench concentrates on the points where the rounding modes differ. It drives exact ties with an even and an odd fraction, so a design that mixed up modes 00 and 01 would round a tie to even upward. It drives negative operands under the +infinity mode, which a sign-blind design would increment. It drives an all-ones fraction that carries into the exponent, including the case one step below the top code: a design that tests overflow only before rounding would emit exponent 0x7FF with a zero fraction but no overflow flag. It also checks exponents of zero and below, the silent bit with noise on the ignored control bits, and idle cycles, where a design that updated without a strobe would change its held result.

// File: rtl/round_pack.sv
module round_pack #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int EI = EXP_W + 2,
  localparam int OW = 1 + EXP_W + FRAC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sign,
  input  logic signed [EI-1:0] in_exp,
  input  logic [FRAC_W-1:0]    in_frac,
  input  logic                 in_guard,
  input  logic                 in_round,
  input  logic                 in_sticky,
  input  logic                 in_invalid,
  input  logic [7:0]           ctrl,
  output logic                 out_valid,
  output logic [OW-1:0]        out_result,
  output logic                 out_ovf,
  output logic                 out_unf,
  output logic                 out_inv
);

  typedef enum logic [1:0] {
    RM_NEAR  = 2'b00,
    RM_EVEN  = 2'b01,
    RM_POS   = 2'b10,
    RM_TRUNC = 2'b11
  } rmode_t;

  localparam logic signed [EI-1:0] EZERO = '0;
  localparam logic signed [EI-1:0] ETOP  = EI'((1 << EXP_W) - 1);

  rmode_t               mode;
  logic                 inc;
  logic [FRAC_W:0]      sum;
  logic                 carry;
  logic signed [EI-1:0] exp_r;
  logic                 unf, ovf;
  logic [OW-1:0]        packed_w;
  logic                 ctrl_unused;

  assign mode        = rmode_t'(ctrl[7:6]);
  assign ctrl_unused = ^ctrl[4:0];

  always_comb begin
    case (mode)
      RM_NEAR:  inc = in_guard;
      RM_EVEN:  inc = in_guard & (in_round | in_sticky | in_frac[0]);
      RM_POS:   inc = ~in_sign & (in_guard | in_round | in_sticky);
      default:  inc = 1'b0;
    endcase
  end

  assign sum   = {1'b0, in_frac} + (FRAC_W+1)'(inc);
  assign carry = sum[FRAC_W];
  assign exp_r = in_exp + $signed({{(EI-1){1'b0}}, carry});
  assign unf   = (in_exp <= EZERO);
  assign ovf   = !unf && (exp_r >= ETOP);

  always_comb begin
    if (unf)      packed_w = {in_sign, {(OW-1){1'b0}}};
    else if (ovf) packed_w = {in_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else          packed_w = {in_sign, exp_r[EXP_W-1:0], sum[FRAC_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ovf    <= 1'b0;
      out_unf    <= 1'b0;
      out_inv    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= packed_w;
        out_ovf    <= ovf;
        out_unf    <= unf;
        out_inv    <= in_invalid & ctrl[5];
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result)));
  assert_ovf_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |-> (out_result[OW-2:FRAC_W] == {EXP_W{1'b1}} && out_result[FRAC_W-1:0] == '0));
  assert_normal_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ovf && !out_unf) |->
      (out_result[OW-2:FRAC_W] != '0 && out_result[OW-2:FRAC_W] != {EXP_W{1'b1}}));
  assert_unf_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_unf |-> (out_result[OW-2:0] == '0 && !out_ovf));
  assert_silent_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ctrl[5]) |=> !out_inv);
  assert_truncate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl[7:6] == 2'b11 && in_exp > EZERO && in_exp < ETOP) |=>
      (out_result[FRAC_W-1:0] == $past(in_frac)));

endmodule

// File: tb/tb_round_pack.sv
module tb_round_pack;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_sign = 1'b0;
  logic signed [12:0] in_exp = '0;
  logic [51:0]        in_frac = '0;
  logic               in_guard = 1'b0, in_round = 1'b0, in_sticky = 1'b0, in_invalid = 1'b0;
  logic [7:0]         ctrl = '0;
  logic               out_valid;
  logic [63:0]        out_result;
  logic               out_ovf, out_unf, out_inv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        e_valid = 0;
  logic [63:0] e_result = '0;
  logic        e_ovf = 0, e_unf = 0, e_inv = 0;
  string       tag = "R1", e_tag = "R1";

  round_pack dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_frac(in_frac), .in_guard(in_guard), .in_round(in_round),
    .in_sticky(in_sticky), .in_invalid(in_invalid), .ctrl(ctrl),
    .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf),
    .out_unf(out_unf), .out_inv(out_inv)
  );

  always #5 clk = ~clk;

  function automatic logic [66:0] model(input logic s, input int e, input longint f,
      input logic g, input logic r, input logic st, input logic iv, input logic [7:0] c);
    longint m;
    int     ee;
    bit     up;
    logic   ov, un;
    logic [63:0] res;
    case (c[7:6])
      2'd0: up = g;
      2'd1: up = g && (r || st || f[0]);
      2'd2: up = !s && (g || r || st);
      default: up = 0;
    endcase
    m  = f + (up ? 1 : 0);
    ee = e;
    if (m >= (longint'(1) << 52)) begin m = 0; ee = e + 1; end
    un = (e <= 0);
    ov = !un && (ee >= 2047);
    if (un) res = {s, 63'd0};
    else if (ov) res = {s, 11'h7ff, 52'd0};
    else res = {s, ee[10:0], m[51:0]};
    return {iv && c[5], un, ov, res};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= 0; e_result <= '0; e_ovf <= 0; e_unf <= 0; e_inv <= 0;
    end else begin
      e_valid <= in_valid;
      e_tag   <= tag;
      if (in_valid)
        {e_inv, e_unf, e_ovf, e_result} <= model(in_sign, int'(in_exp), longint'(in_frac),
                                                 in_guard, in_round, in_sticky, in_invalid, ctrl);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ({out_valid, out_result, out_ovf, out_unf, out_inv} !==
          {e_valid, e_result, e_ovf, e_unf, e_inv}) begin
        errors++;
        $display("FAIL %s: got v=%b res=%h o=%b u=%b i=%b expected v=%b res=%h o=%b u=%b i=%b",
          e_tag, out_valid, out_result, out_ovf, out_unf, out_inv,
          e_valid, e_result, e_ovf, e_unf, e_inv);
      end
    end
  end

  task automatic put(input string t, input logic s, input int e, input logic [51:0] f,
                     input logic g, input logic r, input logic st, input logic iv, input logic [7:0] c);
    @(negedge clk);
    tag = t; in_valid = 1; in_sign = s; in_exp = 13'(e); in_frac = f;
    in_guard = g; in_round = r; in_sticky = st; in_invalid = iv; ctrl = c;
  endtask

  task automatic idle(input string t);
    @(negedge clk);
    tag = t; in_valid = 0; in_frac = ~in_frac; in_exp = 13'(5); in_sign = ~in_sign;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, out_result, out_ovf, out_unf, out_inv} !== 68'd0) begin
      errors++;
      $display("FAIL R1 reset: got %h expected 0", {out_valid, out_result, out_ovf, out_unf, out_inv});
    end
    rst_n = 1;
    put("R2 guard up",      0, 1023, 52'h12345, 1, 0, 0, 0, 8'h20);
    put("R2 no guard",      1, 1000, 52'h12345, 0, 1, 1, 0, 8'h20);
    put("R3 tie even",      0, 1023, 52'h10, 1, 0, 0, 0, 8'h60);
    put("R3 tie odd",       0, 1023, 52'h11, 1, 0, 0, 0, 8'h60);
    put("R3 above half",    1, 900,  52'h10, 1, 0, 1, 0, 8'h60);
    put("R4 pos sticky",    0, 1023, 52'h10, 0, 0, 1, 0, 8'ha0);
    put("R4 neg guard",     1, 1023, 52'h10, 1, 1, 1, 0, 8'ha0);
    put("R5 truncate",      0, 1023, 52'h10, 1, 1, 1, 0, 8'he0);
    put("R6 carry",         0, 100,  {52{1'b1}}, 1, 0, 0, 0, 8'h00);
    put("R7 post-round ovf",1, 2046, {52{1'b1}}, 1, 0, 0, 0, 8'h20);
    put("R7 at top",        0, 2047, 52'h0, 0, 0, 0, 0, 8'h20);
    put("R7 above top",     1, 3000, 52'h5, 0, 0, 0, 0, 8'h20);
    put("R10 max normal",   0, 2046, {52{1'b1}}, 0, 1, 1, 0, 8'h20);
    put("R8 zero exp",      0, 0,    52'h777, 1, 0, 0, 0, 8'h20);
    put("R8 negative exp",  1, -5,   {52{1'b1}}, 1, 1, 1, 0, 8'h00);
    put("R9 invalid pass",  0, 1023, 52'h1, 0, 0, 0, 1, 8'h3f);
    put("R9 silent",        0, 1023, 52'h1, 0, 0, 0, 1, 8'h1f);
    put("R9 low bits",      0, 1023, 52'h1, 1, 0, 0, 1, 8'h2a);
    idle("R1 hold");
    idle("R1 hold 2");
    put("R10 pack",         1, 1, 52'habcdef0123456, 0, 0, 0, 0, 8'h20);
    for (int i = 0; i < 200; i++) begin
      put("R10 sweep", 1'(i), 2040 + (i % 10), 52'({$urandom, $urandom}),
          1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
      if (i % 7 == 0) idle("R1 gap");
    end
    idle("R1 end");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule